// File: doc/BRIEF.md
# Nibble-Bus Port Expander Link Controller

This block is the controller end of a narrow multiplexed link to an external port expander that offers four extra 4-bit ports, numbered 4 to 7. A client presents a one-cycle request carrying an operation (read, write, OR-merge or AND-merge), a 3-bit port number and a 4-bit operand. The controller runs an address phase, then a data phase, over a shared 4-bit bus that is split into an output, an output enable and an input. A single strobe line frames the two phases. When the strobe falls, the expander takes in the address nibble. When the strobe rises, the transfer is complete.

The state machine has three states.
- `ST_IDLE`: strobe high, bus released.
- `ST_ADDR`: strobe high, address nibble driven.
- `ST_DATA`: strobe low; the operand is driven, or the bus is released for a read.

It has four transitions.
- *accept*, `ST_IDLE`→`ST_ADDR`: a valid request names port 4 to 7.
- *addr_done*, `ST_ADDR`→`ST_DATA`: `PHASE_CLKS` cycles have elapsed.
- *finish*, `ST_DATA`→`ST_IDLE`: `PHASE_CLKS` cycles have elapsed. This transition also raises `done` for one cycle.
- *hold*: any state stays where it is while its counter runs.

Any `PHASE_CLKS` value below 2 is treated as 2.

Top module: `nbx_link`

## Requirements
- R1: After reset `strobe`=1, `nib_oe`=0, `busy`=0, `done`=0 and `rd_data`=0.
- R2: On accepting a request, the controller drives nibble {op[1:0], port[1:0]} with `nib_oe`=1 and `strobe`=1 for `PHASE_CLKS` cycles. The op codes are 00 read, 01 write, 10 OR, 11 AND. The port field is the port number minus 4 (port 4 → 00, port 7 → 11).
- R3: After the address phase, `strobe` stays low for exactly `PHASE_CLKS` cycles and then returns high.
- R4: For write, OR and AND, `nib_out` carries the request's operand with `nib_oe`=1 throughout the strobe-low phase.
- R5: For a read, `nib_oe`=0 throughout the strobe-low phase. `nib_in` is sampled at the clock edge one cycle before the strobe rises. `rd_data` then becomes {4'b0000, sampled nibble}. Any operation other than a read leaves `rd_data` unchanged.
- R6: `busy` is high from the cycle after acceptance until the strobe returns high, which is 2×`PHASE_CLKS` cycles.
- R7: `done` is high for exactly one cycle: the first cycle in which the strobe is high again.
- R8: A request that arrives while `busy` is high is ignored. It starts no transfer and does not alter the transfer in progress.
- R9: A request whose port number is below 4 (`req_port[2]`=0) is ignored. `busy` stays 0 and the bus stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, sampled in idle |
| req_op | input | 2 | Operation: 00 read, 01 write, 10 OR, 11 AND |
| req_port | input | 3 | Remote port number, 4 to 7 accepted |
| req_data | input | 4 | Operand nibble |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Zero-extended nibble from last read |
| strobe | output | 1 | Phase strobe, high when idle |
| nib_out | output | 4 | Nibble bus drive value |
| nib_oe | output | 1 | Nibble bus drive enable |
| nib_in | input | 4 | Nibble bus receive value |

## Verification
The bench counts the exact cycles of each phase and of `busy`. An off-by-one in the phase counter would stretch or shorten a phase or the busy window. The bench checks the address nibble's bit order, because a swapped op and port field would hit the wrong remote port or run the wrong merge. A behavioural expander only drives `nib_in` while the strobe is low for a read. A controller that kept driving the bus would be flagged as contention, and one that sampled too late would capture a dead bus. The bench also fires requests mid-transfer and requests with port numbers below 4. A design that accepted either would corrupt a port value that the bench reads back.

// File: rtl/nbx_pkg.sv
package nbx_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_OR    = 2'b10,
        OP_AND   = 2'b11
    } nbx_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ADDR = 2'b01,
        ST_DATA = 2'b10
    } nbx_state_e;

    typedef struct packed {
        nbx_op_e    op;
        logic [1:0] sel;
        logic [3:0] operand;
    } nbx_req_t;

endpackage

// File: rtl/nbx_phase_timer.sv
module nbx_phase_timer #(
    parameter int PHASE_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic last,
    output logic pre_last
);
    localparam int EFF = (PHASE_CLKS < 2) ? 2 : PHASE_CLKS;
    localparam int CW  = $clog2(EFF + 1);
    localparam logic [CW-1:0] LAST_V = CW'(EFF - 1);
    localparam logic [CW-1:0] PRE_V  = CW'(EFF - 2);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (run)     cnt_q <= (cnt_q == LAST_V) ? '0 : cnt_q + 1'b1;
    end

    assign last     = run && (cnt_q == LAST_V);
    assign pre_last = run && (cnt_q == PRE_V);

    // R2 R3: the counter never leaves its phase window
    assert_cnt_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_V);
endmodule

// File: rtl/nbx_req_latch.sv
module nbx_req_latch
    import nbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] op_in,
    input  logic [1:0] sel_in,
    input  logic [3:0] operand_in,
    output logic [3:0] addr_nib,
    output logic [3:0] operand,
    output logic       is_read
);
    nbx_req_t held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '{op: OP_READ, sel: 2'b00, operand: 4'h0};
        end else if (load) begin
            held_q.op      <= nbx_op_e'(op_in);
            held_q.sel     <= sel_in;
            held_q.operand <= operand_in;
        end
    end

    assign addr_nib = {held_q.op, held_q.sel};
    assign operand  = held_q.operand;
    assign is_read  = (held_q.op == OP_READ);

    // R8: held request only changes when a load is granted
    assert_held_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(held_q));
endmodule

// File: rtl/nbx_rd_capture.sv
module nbx_rd_capture #(
    parameter int NIB_W = 4,
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic [NIB_W-1:0] nib_in,
    output logic [OUT_W-1:0] rd_data
);
    localparam int PAD_W = OUT_W - NIB_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= '0;
        else if (sample) rd_data <= {{PAD_W{1'b0}}, nib_in};
    end

    // R5: result held between reads
    assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !sample |=> $stable(rd_data));
    // R5: upper bits always zero
    assert_rd_zero_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[OUT_W-1:NIB_W] == '0);
endmodule

// File: rtl/nbx_link.sv
module nbx_link
    import nbx_pkg::*;
#(
    parameter int PHASE_CLKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic [2:0] req_port,
    input  logic [3:0] req_data,
    output logic       busy,
    output logic       done,
    output logic [7:0] rd_data,
    output logic       strobe,
    output logic [3:0] nib_out,
    output logic       nib_oe,
    input  logic [3:0] nib_in
);
    nbx_state_e state_q, state_d;
    logic       accept, last, pre_last, done_q, is_read;
    logic [3:0] addr_nib, operand;

    assign accept = (state_q == ST_IDLE) && req_valid && req_port[2];

    nbx_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(accept),
        .run(state_q != ST_IDLE), .last(last), .pre_last(pre_last)
    );

    nbx_req_latch u_req (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .op_in(req_op), .sel_in(req_port[1:0]), .operand_in(req_data),
        .addr_nib(addr_nib), .operand(operand), .is_read(is_read)
    );

    nbx_rd_capture #(.NIB_W(4), .OUT_W(8)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .sample((state_q == ST_DATA) && pre_last && is_read),
        .nib_in(nib_in), .rd_data(rd_data)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_ADDR;
            ST_ADDR: if (last)   state_d = ST_DATA;
            ST_DATA: if (last)   state_d = ST_IDLE;
            default:             state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_DATA) && last;
        end
    end

    always_comb begin
        strobe  = 1'b1;
        nib_oe  = 1'b0;
        nib_out = 4'h0;
        busy    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ADDR: begin
                busy    = 1'b1;
                nib_oe  = 1'b1;
                nib_out = addr_nib;
            end
            ST_DATA: begin
                busy    = 1'b1;
                strobe  = 1'b0;
                nib_oe  = !is_read;
                nib_out = is_read ? 4'h0 : operand;
            end
            default: ;
        endcase
    end

    assign done = done_q;

    // R2: address must be on the bus when the strobe falls
    assert_addr_before_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe) |-> $past(nib_oe) && $past(busy));
    // R7: completion pulse coincides with strobe return
    assert_done_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> done);
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: busy ends only with strobe high
    assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> strobe);
    // R5: no drive while the expander answers a read
    assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && is_read) |-> !nib_oe);
    // R8: no second accept while a transfer runs
    assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> busy || done);
endmodule

// File: tb/sim_nbx_link.sv
module sim_nbx_link;
    localparam int P = 3;

    logic       clk = 0, rst_n = 0;
    logic       req_valid = 0;
    logic [1:0] req_op = 0;
    logic [2:0] req_port = 0;
    logic [3:0] req_data = 0;
    logic       busy, done, strobe, nib_oe;
    logic [7:0] rd_data;
    logic [3:0] nib_out, nib_in;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    nbx_link #(.PHASE_CLKS(P)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_port(req_port), .req_data(req_data), .busy(busy), .done(done),
        .rd_data(rd_data), .strobe(strobe), .nib_out(nib_out),
        .nib_oe(nib_oe), .nib_in(nib_in)
    );

    // behavioural expander
    logic [3:0] mem [4];
    logic [3:0] m_addr = 0, m_data = 0;
    logic       m_prev = 1;
    assign nib_in = (!strobe && m_addr[3:2] == 2'b00) ? mem[m_addr[1:0]] : 4'h0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (strobe && nib_oe) m_addr <= nib_out;
            if (!strobe && nib_oe) m_data <= nib_out;
            if (!strobe && m_addr[3:2] == 2'b00 && nib_oe) begin
                checks++; errors++;
                $display("FAIL R5 bus contention: nib_oe=%b expected 0", nib_oe);
            end
            if (strobe && !m_prev) begin
                unique case (m_addr[3:2])
                    2'b00: ;
                    2'b01: mem[m_addr[1:0]] <= m_data;
                    2'b10: mem[m_addr[1:0]] <= mem[m_addr[1:0]] | m_data;
                    2'b11: mem[m_addr[1:0]] <= mem[m_addr[1:0]] & m_data;
                endcase
            end
            m_prev <= strobe;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive a request for one edge; returns at negedge after that edge
    task automatic issue(input logic [1:0] op, input logic [2:0] port, input logic [3:0] d);
        req_valid = 1; req_op = op; req_port = port; req_data = d;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic finish_txn();
        int guard = 0;
        while (!done && guard < 100) begin @(negedge clk); guard++; end
        @(negedge clk);
    endtask

    task automatic do_read(input logic [2:0] port, output logic [7:0] val);
        issue(2'b00, port, 4'h0);
        finish_txn();
        val = rd_data;
    endtask

    task automatic t_reset();
        chk("R1 strobe", {7'b0, strobe}, 8'd1);
        chk("R1 nib_oe", {7'b0, nib_oe}, 8'd0);
        chk("R1 busy", {7'b0, busy}, 8'd0);
        chk("R1 done", {7'b0, done}, 8'd0);
        chk("R1 rd_data", rd_data, 8'h00);
    endtask

    task automatic t_write_timing();
        issue(2'b01, 3'd5, 4'h9);
        for (int i = 0; i < P; i++) begin
            chk("R2 addr strobe high", {7'b0, strobe}, 8'd1);
            chk("R2 addr oe", {7'b0, nib_oe}, 8'd1);
            chk("R2 addr nibble write port5", {4'b0, nib_out}, 8'h05);
            chk("R6 busy addr", {7'b0, busy}, 8'd1);
            @(negedge clk);
        end
        for (int i = 0; i < P; i++) begin
            chk("R3 strobe low", {7'b0, strobe}, 8'd0);
            chk("R4 operand oe", {7'b0, nib_oe}, 8'd1);
            chk("R4 operand nibble", {4'b0, nib_out}, 8'h09);
            chk("R6 busy data", {7'b0, busy}, 8'd1);
            chk("R7 no early done", {7'b0, done}, 8'd0);
            @(negedge clk);
        end
        chk("R3 strobe back high", {7'b0, strobe}, 8'd1);
        chk("R6 busy low", {7'b0, busy}, 8'd0);
        chk("R7 done pulse", {7'b0, done}, 8'd1);
        chk("R5 rd_data kept on write", rd_data, 8'h00);
        @(negedge clk);
        chk("R7 done one cycle", {7'b0, done}, 8'd0);
    endtask

    task automatic t_read_timing();
        int bcnt = 0;
        issue(2'b00, 3'd7, 4'hF);
        chk("R2 addr nibble read port7", {4'b0, nib_out}, 8'h03);
        while (busy && bcnt < 50) begin
            if (!strobe) chk("R5 read releases bus", {7'b0, nib_oe}, 8'd0);
            bcnt++; @(negedge clk);
        end
        chk("R6 busy length", 8'(bcnt), 8'(2 * P));
        chk("R5 read value port7", rd_data, 8'h0C);
    endtask

    task automatic t_merge_ops();
        logic [7:0] v;
        issue(2'b10, 3'd6, 4'h8); finish_txn();
        do_read(3'd6, v); chk("R4 OR merge port6", v, 8'h0B);
        issue(2'b11, 3'd6, 4'h6); finish_txn();
        do_read(3'd6, v); chk("R4 AND merge port6", v, 8'h02);
        issue(2'b01, 3'd4, 4'hE); finish_txn();
        do_read(3'd4, v); chk("R4 write port4", v, 8'h0E);
        do_read(3'd5, v); chk("R5 read port5 after write", v, 8'h09);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] v;
        issue(2'b01, 3'd4, 4'h3);
        @(negedge clk);
        issue(2'b01, 3'd7, 4'h1);
        finish_txn();
        for (int i = 0; i < 2 * P + 2; i++) begin
            chk("R8 no second transfer", {7'b0, busy}, 8'd0);
            @(negedge clk);
        end
        do_read(3'd7, v); chk("R8 port7 untouched", v, 8'h0C);
        do_read(3'd4, v); chk("R8 first transfer intact", v, 8'h03);
    endtask

    task automatic t_low_port();
        logic [7:0] v;
        issue(2'b01, 3'd2, 4'h0);
        chk("R9 busy stays low", {7'b0, busy}, 8'd0);
        chk("R9 bus released", {7'b0, nib_oe}, 8'd0);
        chk("R9 strobe high", {7'b0, strobe}, 8'd1);
        @(negedge clk);
        chk("R9 no done", {7'b0, done}, 8'd0);
        do_read(3'd6, v); chk("R9 port6 unchanged", v, 8'h02);
    endtask

    initial begin
        mem[0] = 4'h5; mem[1] = 4'hA; mem[2] = 4'h3; mem[3] = 4'hC;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_write_timing();
        t_read_timing();
        t_merge_ops();
        t_busy_ignore();
        t_low_port();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule